// File: doc/BRIEF.md
# Byte-Serial Register Exchange Datapath

This block is a small 8-bit execution unit fed by a stream of instruction bytes. A byte is taken on every clock edge where `in_valid` is high. The unit decodes each opcode and, for two-byte instructions, waits for the data byte that follows. It then updates its seven general registers (A, B, C, D, E, H, L) and its flag byte.

It runs three operations:
- **Load-immediate** writes a data byte into any general register.
- **XOR-immediate** combines the accumulator with a data byte and sets the sign, zero and parity flags from the result.
- **Pair exchange** swaps the 16-bit HL pair with either BC or DE.

Every register and the flag byte drive output ports, so a surrounding model can compare the full state after each instruction. A one-cycle completion pulse marks the moment to compare.

Top module: `xbyte_core`

## Requirements
- R1: A synchronous active-low reset clears all seven registers and the flag byte to 00h and returns the fetch sequencer to expecting an opcode, even when a reset interrupts a two-byte instruction.
- R2: An opcode of the form 00 rrr 110 is a load-immediate with target code r = 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 7 A. The next accepted byte is written to that register in the cycle it is accepted, and the flag byte does not change.
- R3: Opcode EEh is XOR-immediate: when the next byte is accepted, A becomes A XOR that byte.
- R4: The flag byte has S at bit 7, Z at bit 6, AC at bit 4, P at bit 2 and CY at bit 0, and bits 5, 3 and 1 are always 0. XOR-immediate sets S to result bit 7, Z when the result is 00h, and P when the result has an even count of ones. It clears AC and CY.
- R5: Opcode E3h swaps BC with HL (B with H, C with L), and opcode EBh swaps DE with HL (D with H, E with L). Each takes effect in the cycle the single opcode byte is accepted and leaves the flags unchanged.
- R6: The sequence E3h, EBh, E3h exchanges the contents of BC and DE and leaves HL at its starting value.
- R7: `instr_done` is high for exactly the one cycle in which the register outputs first show a completed instruction, and low after the first byte of a two-byte instruction.
- R8: Any other opcode, including 36h, is treated as a single byte that changes no register or flag and raises no `instr_done`. The byte after it is decoded as a new opcode.
- R9: A cycle with `in_valid` low changes nothing and raises no `instr_done`, including while the unit waits for a data byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Byte on `in_byte` is accepted this edge |
| in_byte | input | 8 | Instruction stream byte |
| instr_done | output | 1 | One-cycle pulse per completed instruction |
| a_q | output | 8 | Accumulator |
| b_q | output | 8 | Register B |
| c_q | output | 8 | Register C |
| d_q | output | 8 | Register D |
| e_q | output | 8 | Register E |
| h_q | output | 8 | Register H |
| l_q | output | 8 | Register L |
| flags_q | output | 8 | Flag byte (S7 Z6 AC4 P2 CY0) |

## Verification
The XOR path is tried with four operand pairs:
- The first gives an even-parity nonzero result.
- The second gives a zero result.
- The third gives a single set bit in position 7, which has odd parity.
- The fourth gives an all-ones result.

Together these separate S, Z and P from one another and from a stuck or inverted parity.

The loads write a distinct value to every target code, which exposes a wrong register selection. The exchanges start from pairs whose high and low bytes all differ, so crossed bytes or a swapped pair select show up. The three-exchange chain checks that consecutive swaps compose correctly.

Three further patterns probe the fetch sequencer:
- Unused opcodes, including the hole at target code 6.
- A gap in `in_valid` between an opcode and its data byte.
- A reset in the middle of an instruction.

// File: rtl/xbyte_pkg.sv
// Package: shared encodings for the byte-serial exchange datapath.
// Assumes an 8-bit data path; flag bit positions are fixed by the flag layout.
package xbyte_pkg;

    localparam int DW     = 8;
    localparam int NREG   = 8;   // register slots addressed by a 3-bit code
    localparam int SELW   = $clog2(NREG);

    // Register target codes used by load-immediate
    localparam logic [SELW-1:0] RC_B   = 3'd0;
    localparam logic [SELW-1:0] RC_C   = 3'd1;
    localparam logic [SELW-1:0] RC_D   = 3'd2;
    localparam logic [SELW-1:0] RC_E   = 3'd3;
    localparam logic [SELW-1:0] RC_H   = 3'd4;
    localparam logic [SELW-1:0] RC_L   = 3'd5;
    localparam logic [SELW-1:0] RC_GAP = 3'd6;   // no register behind this code
    localparam logic [SELW-1:0] RC_A   = 3'd7;

    // Opcode values
    localparam logic [DW-1:0] OPC_XORI    = 8'hEE;
    localparam logic [DW-1:0] OPC_SWAP_DE = 8'hEB;
    localparam logic [DW-1:0] OPC_SWAP_BC = 8'hE3;

    // Flag bit positions
    localparam int FB_S  = 7;
    localparam int FB_Z  = 6;
    localparam int FB_AC = 4;
    localparam int FB_P  = 2;
    localparam int FB_CY = 0;

    typedef enum logic {
        ST_OPCODE = 1'b0,
        ST_IMMED  = 1'b1
    } fetch_st_t;

    typedef enum logic [1:0] {
        OK_NONE = 2'd0,
        OK_LDI  = 2'd1,
        OK_XORI = 2'd2,
        OK_SWAP = 2'd3
    } op_kind_t;

    typedef struct packed {
        op_kind_t        kind;
        logic [SELW-1:0] dst;
        logic            pair_de;
        logic            needs_imm;
    } dec_t;

endpackage

// File: rtl/xbyte_decode.sv
// Module: xbyte_decode
// Purely combinational opcode classifier. It turns one opcode byte into an
// operation kind, a destination code, an exchange-pair select and a flag
// saying whether a data byte must follow. Assumes the caller presents it
// only with bytes in opcode position.
module xbyte_decode
    import xbyte_pkg::*;
(
    input  logic [DW-1:0] opc,
    output dec_t          dec
);

    logic is_ldi_shape;

    // Recognise the 00 rrr 110 load pattern, skipping the unused target code
    always_comb begin
        is_ldi_shape = (opc[7:6] == 2'b00) && (opc[2:0] == 3'b110)
                       && (opc[5:3] != RC_GAP);
    end

    // Classify the opcode; anything unmatched stays OK_NONE
    always_comb begin
        dec           = '0;
        dec.kind      = OK_NONE;
        if (is_ldi_shape) begin
            dec.kind      = OK_LDI;
            dec.dst       = opc[5:3];
            dec.needs_imm = 1'b1;
        end else if (opc == OPC_XORI) begin
            dec.kind      = OK_XORI;
            dec.dst       = RC_A;
            dec.needs_imm = 1'b1;
        end else if (opc == OPC_SWAP_DE) begin
            dec.kind      = OK_SWAP;
            dec.pair_de   = 1'b1;
        end else if (opc == OPC_SWAP_BC) begin
            dec.kind      = OK_SWAP;
            dec.pair_de   = 1'b0;
        end
    end

endmodule

// File: rtl/xbyte_flaggen.sv
// Module: xbyte_flaggen
// Combinational XOR unit with flag formation. It produces the accumulator
// XOR immediate result and the full flag byte: S, Z and even parity from
// the result, AC and CY cleared, and the unused bits held at zero.
module xbyte_flaggen
    import xbyte_pkg::*;
(
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] imm,
    output logic [DW-1:0] result,
    output logic [DW-1:0] flags
);

    // Bitwise combine of accumulator and immediate
    always_comb begin
        result = acc ^ imm;
    end

    // Assemble the flag byte bit by bit from the result
    always_comb begin
        flags        = '0;
        flags[FB_S]  = result[DW-1];
        flags[FB_Z]  = (result == '0);
        flags[FB_AC] = 1'b0;
        flags[FB_P]  = ~(^result);
        flags[FB_CY] = 1'b0;
    end

endmodule

// File: rtl/xbyte_regfile.sv
// Module: xbyte_regfile
// Holds the seven general registers, addressed by their 3-bit target
// codes, and the flag byte. One port writes a single register. A separate
// exchange command swaps HL with BC or DE in one edge. Assumes the control
// logic never raises a write and an exchange in the same cycle. The slot
// for code 6 has no storage and reads zero.
module xbyte_regfile
    import xbyte_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [SELW-1:0]       wr_sel,
    input  logic [DW-1:0]         wr_data,
    input  logic                  swap_en,
    input  logic                  swap_de,
    input  logic                  flag_en,
    input  logic [DW-1:0]         flag_data,
    output logic [NREG-1:0][DW-1:0] rq,
    output logic [DW-1:0]         flags
);

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        if (i == int'(RC_GAP)) begin : g_gap
            assign rq[i] = '0;
        end else begin : g_reg
            logic [DW-1:0] val;
            logic [DW-1:0] swap_src;
            logic          swap_hit;

            // Pick the partner byte this slot takes during an exchange
            always_comb begin
                swap_hit = 1'b0;
                swap_src = val;
                case (i)
                    int'(RC_H): begin
                        swap_hit = 1'b1;
                        swap_src = swap_de ? rq[RC_D] : rq[RC_B];
                    end
                    int'(RC_L): begin
                        swap_hit = 1'b1;
                        swap_src = swap_de ? rq[RC_E] : rq[RC_C];
                    end
                    int'(RC_B): begin
                        swap_hit = !swap_de;
                        swap_src = rq[RC_H];
                    end
                    int'(RC_C): begin
                        swap_hit = !swap_de;
                        swap_src = rq[RC_L];
                    end
                    int'(RC_D): begin
                        swap_hit = swap_de;
                        swap_src = rq[RC_H];
                    end
                    int'(RC_E): begin
                        swap_hit = swap_de;
                        swap_src = rq[RC_L];
                    end
                    default: begin
                        swap_hit = 1'b0;
                        swap_src = val;
                    end
                endcase
            end

            // Slot storage: reset, direct write, or exchange
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    val <= '0;
                end else if (wr_en && (wr_sel == SELW'(i))) begin
                    val <= wr_data;
                end else if (swap_en && swap_hit) begin
                    val <= swap_src;
                end
            end

            assign rq[i] = val;
        end
    end

    // Flag byte storage, only touched by XOR-immediate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (flag_en) begin
            flags <= flag_data;
        end
    end

    AST_SWAP_BC_HL: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_en && !swap_de && !wr_en) |=>
            (rq[RC_H] == $past(rq[RC_B])) && (rq[RC_L] == $past(rq[RC_C])) &&
            (rq[RC_B] == $past(rq[RC_H])) && (rq[RC_C] == $past(rq[RC_L])))
        else $error("BC/HL exchange wrong"); // R5
    AST_SWAP_DE_HL: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_en && swap_de && !wr_en) |=>
            (rq[RC_H] == $past(rq[RC_D])) && (rq[RC_L] == $past(rq[RC_E])) &&
            (rq[RC_D] == $past(rq[RC_H])) && (rq[RC_E] == $past(rq[RC_L])))
        else $error("DE/HL exchange wrong"); // R5
    AST_SWAP_KEEPS_A: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_en && !wr_en && !flag_en) |=> $stable(rq[RC_A]) && $stable(flags))
        else $error("exchange disturbed A or flags"); // R5

endmodule

// File: rtl/xbyte_core.sv
// Module: xbyte_core (top)
// Byte-serial execution unit. A two-state fetch sequencer takes one byte
// per valid cycle. A load-immediate or XOR-immediate opcode is held while
// its data byte is awaited, and the operation completes when that byte
// arrives. An exchange completes when its opcode is accepted. Unknown
// opcodes are dropped. Assumes no back-pressure: every valid byte is taken.
module xbyte_core
    import xbyte_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_byte,
    output logic          instr_done,
    output logic [DW-1:0] a_q,
    output logic [DW-1:0] b_q,
    output logic [DW-1:0] c_q,
    output logic [DW-1:0] d_q,
    output logic [DW-1:0] e_q,
    output logic [DW-1:0] h_q,
    output logic [DW-1:0] l_q,
    output logic [DW-1:0] flags_q
);

    fetch_st_t        state_q;
    op_kind_t         pend_kind_q;
    logic [SELW-1:0]  pend_dst_q;
    dec_t             dec;
    logic [NREG-1:0][DW-1:0] rq;
    logic [DW-1:0]    xor_res;
    logic [DW-1:0]    xor_flags;
    logic             wr_en;
    logic [SELW-1:0]  wr_sel;
    logic [DW-1:0]    wr_data;
    logic             swap_en;
    logic             swap_de;
    logic             flag_en;
    logic             finish;
    logic             take_op;
    logic             take_imm;

    xbyte_decode u_dec (
        .opc (in_byte),
        .dec (dec)
    );

    xbyte_flaggen u_flg (
        .acc    (rq[RC_A]),
        .imm    (in_byte),
        .result (xor_res),
        .flags  (xor_flags)
    );

    xbyte_regfile u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .swap_en   (swap_en),
        .swap_de   (swap_de),
        .flag_en   (flag_en),
        .flag_data (xor_flags),
        .rq        (rq),
        .flags     (flags_q)
    );

    // Qualify the incoming byte by the sequencer position
    always_comb begin
        take_op  = in_valid && (state_q == ST_OPCODE);
        take_imm = in_valid && (state_q == ST_IMMED);
    end

    // Steer register writes, exchange and flag update for this edge
    always_comb begin
        wr_en   = 1'b0;
        wr_sel  = pend_dst_q;
        wr_data = in_byte;
        swap_en = 1'b0;
        swap_de = dec.pair_de;
        flag_en = 1'b0;
        finish  = 1'b0;
        if (take_imm) begin
            finish = 1'b1;
            wr_en  = 1'b1;
            if (pend_kind_q == OK_XORI) begin
                wr_sel  = RC_A;
                wr_data = xor_res;
                flag_en = 1'b1;
            end
        end else if (take_op && (dec.kind == OK_SWAP)) begin
            swap_en = 1'b1;
            finish  = 1'b1;
        end
    end

    // Fetch sequencer and pending-operation holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_OPCODE;
            pend_kind_q <= OK_NONE;
            pend_dst_q  <= '0;
        end else if (take_op && dec.needs_imm) begin
            state_q     <= ST_IMMED;
            pend_kind_q <= dec.kind;
            pend_dst_q  <= dec.dst;
        end else if (take_imm) begin
            state_q     <= ST_OPCODE;
            pend_kind_q <= OK_NONE;
        end
    end

    // Registered completion pulse, aligned with the updated outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            instr_done <= 1'b0;
        end else begin
            instr_done <= finish;
        end
    end

    assign a_q = rq[RC_A];
    assign b_q = rq[RC_B];
    assign c_q = rq[RC_C];
    assign d_q = rq[RC_D];
    assign e_q = rq[RC_E];
    assign h_q = rq[RC_H];
    assign l_q = rq[RC_L];

    AST_XORI_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (take_imm && pend_kind_q == OK_XORI) |=> a_q == ($past(a_q) ^ $past(in_byte)))
        else $error("XOR result wrong"); // R3
    AST_XORI_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (take_imm && pend_kind_q == OK_XORI) |=>
            !flags_q[FB_CY] && !flags_q[FB_AC] && (flags_q[FB_P] == ~(^a_q)) &&
            (flags_q[FB_Z] == (a_q == '0)) && (flags_q[FB_S] == a_q[DW-1]))
        else $error("XOR flags wrong"); // R4
    AST_LDI_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (take_imm && pend_kind_q == OK_LDI) |=> $stable(flags_q))
        else $error("load changed flags"); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !instr_done && $stable(rq) && $stable(flags_q))
        else $error("idle cycle changed state"); // R9
    AST_UNKNOWN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (take_op && dec.kind == OK_NONE) |=>
            !instr_done && $stable(rq) && $stable(flags_q) && (state_q == ST_OPCODE))
        else $error("unknown opcode had an effect"); // R8
    AST_FIRST_BYTE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (take_op && dec.needs_imm) |=> !instr_done)
        else $error("done raised after first byte"); // R7

endmodule

// File: tb/xbyte_core_tb_top.sv
// Directed bench: every scenario task drives bytes, updates a reference
// model and checks the complete register state at the ports.
module xbyte_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       instr_done;
    logic [7:0] a_q, b_q, c_q, d_q, e_q, h_q, l_q, flags_q;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model, indexed by target code (6 unused)
    logic [7:0] m [8];
    logic [7:0] mf;

    always #5 clk = ~clk;

    xbyte_core dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_byte    (in_byte),
        .instr_done (instr_done),
        .a_q        (a_q),
        .b_q        (b_q),
        .c_q        (c_q),
        .d_q        (d_q),
        .e_q        (e_q),
        .h_q        (h_q),
        .l_q        (l_q),
        .flags_q    (flags_q)
    );

    function automatic logic [7:0] flags_of(input logic [7:0] r);
        return {r[7], (r == 8'h00), 1'b0, 1'b0, 1'b0, ~(^r), 1'b0, 1'b0};
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 8; i++) m[i] = 8'h00;
        mf = 8'h00;
    endtask

    task automatic check_val(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        check_val(tag, {a_q, b_q, c_q, d_q, e_q, h_q, l_q, flags_q},
                  {m[7], m[0], m[1], m[2], m[3], m[4], m[5], mf});
    endtask

    task automatic check_done(input string tag, input logic exp);
        check_val(tag, {63'd0, instr_done}, {63'd0, exp});
    endtask

    // One byte accepted at the next rising edge; returns at the following falling edge
    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = 8'hE3;  // looks like an opcode, must be ignored while invalid
    endtask

    task automatic ldi(input logic [2:0] code, input logic [7:0] v);
        send({2'b00, code, 3'b110});
        send(v);
        m[code] = v;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    task automatic t_reset_state();
        do_reset();
        check_regs("R1 reset clears registers and flags");
        check_done("R1 no done after reset", 1'b0);
    endtask

    task automatic t_load_all();
        logic [2:0] codes [7] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd7};
        for (int k = 0; k < 7; k++) begin
            send({2'b00, codes[k], 3'b110});
            check_done("R7 no done after load opcode", 1'b0);
            check_regs("R2 opcode alone changes nothing");
            send(8'h11 * 8'(k + 1));
            m[codes[k]] = 8'h11 * 8'(k + 1);
            check_done("R7 done after load data byte", 1'b1);
            check_regs("R2 load writes target register");
        end
    endtask

    task automatic xori(input logic [7:0] imm, input string tag);
        send(8'hEE);
        send(imm);
        m[7] = m[7] ^ imm;
        mf   = flags_of(m[7]);
        check_done("R7 done after XOR data byte", 1'b1);
        check_regs(tag);
    endtask

    task automatic t_xor();
        ldi(3'd7, 8'h11);
        xori(8'h22, "R3 R4 XOR 11^22 even parity");
        check_val("R4 flag byte 04h for 33h", {56'd0, flags_q}, 64'h04);
        xori(8'h33, "R4 XOR to zero sets Z and P");
        xori(8'h80, "R4 single high bit sets S, odd parity");
        xori(8'h7F, "R3 R4 all-ones result");
    endtask

    task automatic t_ldi_keeps_flags();
        ldi(3'd1, 8'h5A);
        check_regs("R2 load leaves flags unchanged");
    endtask

    task automatic t_xchg();
        ldi(3'd0, 8'h20); ldi(3'd1, 8'h50); ldi(3'd4, 8'h80); ldi(3'd5, 8'h60);
        ldi(3'd2, 8'hA1); ldi(3'd3, 8'hB2);
        send(8'hE3);
        m[0] = 8'h80; m[1] = 8'h60; m[4] = 8'h20; m[5] = 8'h50;
        check_done("R7 done right after exchange opcode", 1'b1);
        check_regs("R5 BC swapped with HL");
        @(negedge clk);
        check_done("R7 done lasts one cycle", 1'b0);
        send(8'hEB);
        m[2] = 8'h20; m[3] = 8'h50; m[4] = 8'hA1; m[5] = 8'hB2;
        check_regs("R5 DE swapped with HL, flags kept");
    endtask

    task automatic t_three_swap();
        ldi(3'd0, 8'h11); ldi(3'd1, 8'h22); ldi(3'd2, 8'h44); ldi(3'd3, 8'h55);
        ldi(3'd4, 8'h00); ldi(3'd5, 8'h00);
        send(8'hE3); send(8'hEB); send(8'hE3);
        m[0] = 8'h44; m[1] = 8'h55; m[2] = 8'h11; m[3] = 8'h22;
        check_regs("R6 three exchanges swap BC and DE, HL kept");
    endtask

    task automatic t_unknown();
        logic [7:0] junk [4] = '{8'h36, 8'h00, 8'hC3, 8'hFF};
        for (int k = 0; k < 4; k++) begin
            send(junk[k]);
            check_done("R8 no done for unknown opcode", 1'b0);
            check_regs("R8 unknown opcode ignored");
        end
        send(8'h36);
        send(8'h16);      // must decode as a fresh opcode: load D
        send(8'h9C);
        m[2] = 8'h9C;
        check_regs("R8 byte after unknown opcode decoded as opcode");
    endtask

    task automatic t_stall();
        send(8'h3E);
        repeat (5) @(negedge clk);
        check_done("R9 no done during stall", 1'b0);
        check_regs("R9 stall changes nothing");
        send(8'hC4);
        m[7] = 8'hC4;
        check_regs("R9 load completes after gap");
    endtask

    task automatic t_reset_mid();
        send(8'h06);   // load B opcode, data never sent
        do_reset();
        send(8'hEB);   // must be an exchange of zeros, not data for B
        check_regs("R1 reset returns sequencer to opcode");
        check_done("R1 exchange after reset completes", 1'b1);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        model_clear();
        t_reset_state();
        t_load_all();
        t_xor();
        t_ldi_keeps_flags();
        t_xchg();
        t_three_swap();
        t_unknown();
        t_stall();
        t_reset_mid();
        finish_run();
    end

    // Watchdog: a hung run is counted as a failure
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        finish_run();
    end

endmodule